// File: doc/BRIEF.md
# Parallel Port Register Interface

This block is the processor-facing register front end of a 24-line parallel I/O controller that runs its ports in basic (unhandshaked) mode. A host reaches four locations through a chip select, separate read and write strobes, a two-bit address and an 8-bit data bus. Three locations are port data registers. The fourth is a command register that either loads the full direction and mode word or sets or clears one bit of port C. The read bus comes with its own output-enable instead of tri-state pins.

The write strobe is brought into the system clock domain through a synchroniser. A write takes effect one clock after the synchronised strobe goes back high. Reads are combinational and appear while the read strobe is low. Every port line has an output value and an output enable, so a pad ring can build the bidirectional pins. Handshake lines for strobed and bidirectional transfers belong to a separate block. Here the group mode fields are only stored and read back.

Top module: `ppi_regif`

## Requirements
- R1: Address 2'b00 selects port A, 2'b01 port B, 2'b10 port C and 2'b11 the command/mode register, for reads and for writes.
- R2: `dout_oe` is 1 only while `cs_n`=0 and `rd_n`=0. It is 0 when chip select is high or no read is in progress.
- R3: After reset the mode register reads back 8'h9B, every output enable is 0 and every output latch is 0.
- R4: A command write with bit 7=1 is a mode set. Bit 4 sets the direction of port A, bit 1 port B, bit 3 port C bits 7:4 and bit 0 port C bits 3:0. In each case 1 means input (output enable 0) and 0 means output (output enable 1).
- R5: Mode-set bits 6:5 (group A mode) and bit 2 (group B mode) are stored and read back, and they do not change any output enable.
- R6: A mode set clears to zero the output latch of every port or port C half that it makes an output.
- R7: A command write with bit 7=0 sets port C bit number {bit3,bit2,bit1} to the value of bit 0. Bits 6:4 are ignored, the other port C bits and the mode register are unchanged, and a port C line that is an input still reads its pin.
- R8: A read of the command address returns the mode word with bit 7 always 1.
- R9: A port read returns the output latch for lines set as outputs and the live pin value, with no latch, for lines set as inputs. Port C decides this separately for each 4-bit half.
- R10: With SYNC_STAGES=2, a write reaches the outputs on the third rising clock edge after `wr_n` rises, and not before.
- R11: A write strobe given while `cs_n` is high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| dout_oe | output | 1 | Read data bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pb_in | input | 8 | Port B pin values |
| pc_in | input | 8 | Port C pin values |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 8 | Port A per-line output enable |
| pb_oe | output | 8 | Port B per-line output enable |
| pc_oe | output | 8 | Port C per-line output enable |

## Verification
A corrupted mode register shows up at once in two places: the output-enable buses and the command-address readback. Both are checked after every one of the sixteen direction combinations. A latch that was not cleared or was wrongly loaded shows on the output bus on the first sample after the write commits, and a port read shows the same fault in the same cycle. A bit operation that lands on the wrong bit is caught by a port C readback after each of the sixteen set and clear commands. The commit edge is checked on both sides, so a write that lands one cycle early or late shows as a mismatch on the port output.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
   localparam logic [1:0] SEL_PA  = 2'b00;
   localparam logic [1:0] SEL_PB  = 2'b01;
   localparam logic [1:0] SEL_PC  = 2'b10;
   localparam logic [1:0] SEL_CMD = 2'b11;

   // field order follows the command word bit positions 6..0
   typedef struct packed {
      logic [1:0] grp_a_mode;
      logic       a_in;
      logic       cu_in;
      logic       grp_b_mode;
      logic       b_in;
      logic       cl_in;
   } mode_word_t;

   localparam mode_word_t MODE_RST = 7'h1B;
endpackage

// File: rtl/ppi_strobe_sync.sv
module ppi_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_n,
   output logic released
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;
   logic              prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sr   <= '1;
         prev <= 1'b1;
      end else begin
         sr   <= {sr[STAGES-2:0], strobe_n};
         prev <= sr[STAGES-1];
      end
   end

   assign released = sr[STAGES-1] & ~prev;

   // R10
   release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      released |=> !released);
endmodule

// File: rtl/ppi_cmd_decode.sv
module ppi_cmd_decode
   import ppi_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_n,
   input  logic         cs_n,
   input  logic [1:0]   addr,
   input  logic [W-1:0] din,
   input  logic         commit,
   output logic         mode_set,
   output logic         bit_op,
   output logic         ld_a,
   output logic         ld_b,
   output logic         ld_c,
   output logic [W-1:0] data,
   output logic [6:0]   mode_word,
   output logic [2:0]   bit_sel,
   output logic         bit_val
);
   logic         h_sel;
   logic [1:0]   h_addr;
   logic [W-1:0] h_data;

   // capture the bus while the raw strobe is low
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         h_sel  <= 1'b0;
         h_addr <= '0;
         h_data <= '0;
      end else if (!wr_n) begin
         h_sel  <= ~cs_n;
         h_addr <= addr;
         h_data <= din;
      end
   end

   logic go;
   assign go        = commit & h_sel;
   assign mode_set  = go & (h_addr == SEL_CMD) & h_data[7];
   assign bit_op    = go & (h_addr == SEL_CMD) & ~h_data[7];
   assign ld_a      = go & (h_addr == SEL_PA);
   assign ld_b      = go & (h_addr == SEL_PB);
   assign ld_c      = go & (h_addr == SEL_PC);
   assign data      = h_data;
   assign mode_word = h_data[6:0];
   assign bit_sel   = h_data[3:1];
   assign bit_val   = h_data[0];

   // R1
   one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      $countones({mode_set, bit_op, ld_a, ld_b, ld_c}) <= 1);
endmodule

// File: rtl/ppi_mode_reg.sv
module ppi_mode_reg
   import ppi_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       mode_set,
   input  logic [6:0] word_in,
   output mode_word_t mode_q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)           mode_q <= MODE_RST;
      else if (mode_set) mode_q <= mode_word_t'(word_in);
   end

   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !mode_set |=> $stable(mode_q));
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
   parameter int W     = 8,
   parameter int SEL_W = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [W-1:0]     clr_mask,
   input  logic             ld,
   input  logic [W-1:0]     ld_data,
   input  logic             bit_we,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             bit_val,
   output logic [W-1:0]     q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)         q <= '0;
      else if (clr)    q <= q & ~clr_mask;
      else if (ld)     q <= ld_data;
      else if (bit_we) q[bit_sel] <= bit_val;
   end

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      clr |=> ((q & $past(clr_mask)) == '0));

   // R7
   bit_write_chk: assert property (@(posedge clk) disable iff (rst)
      (bit_we && !clr && !ld) |=>
         (((q >> $past(bit_sel)) & W'(1)) == W'($past(bit_val))));
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
   import ppi_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [1:0]   addr,
   input  mode_word_t   mode_q,
   input  logic [W-1:0] la,
   input  logic [W-1:0] lb,
   input  logic [W-1:0] lc,
   input  logic [W-1:0] pa_in,
   input  logic [W-1:0] pb_in,
   input  logic [W-1:0] pc_in,
   output logic [W-1:0] rdata
);
   localparam int H = W / 2;
   logic [W-1:0] c_view;

   assign c_view = {mode_q.cu_in ? pc_in[W-1:H] : lc[W-1:H],
                    mode_q.cl_in ? pc_in[H-1:0] : lc[H-1:0]};

   always_comb begin
      case (addr)
         SEL_PA:  rdata = mode_q.a_in ? pa_in : la;
         SEL_PB:  rdata = mode_q.b_in ? pb_in : lb;
         SEL_PC:  rdata = c_view;
         default: rdata = {1'b1, mode_q};
      endcase
   end
endmodule

// File: rtl/ppi_regif.sv
module ppi_regif
   import ppi_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PORT_W      = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [PORT_W-1:0] din,
   output logic [PORT_W-1:0] dout,
   output logic              dout_oe,
   input  logic [PORT_W-1:0] pa_in,
   input  logic [PORT_W-1:0] pb_in,
   input  logic [PORT_W-1:0] pc_in,
   output logic [PORT_W-1:0] pa_out,
   output logic [PORT_W-1:0] pb_out,
   output logic [PORT_W-1:0] pc_out,
   output logic [PORT_W-1:0] pa_oe,
   output logic [PORT_W-1:0] pb_oe,
   output logic [PORT_W-1:0] pc_oe
);
   localparam int HALF = PORT_W / 2;

   generate
      if (PORT_W != 8) begin : g_bad_w
         $error("PORT_W must be 8 to match the command word layout");
      end
   endgenerate

   logic              commit;
   logic              mode_set, bit_op, ld_a, ld_b, ld_c, bit_val;
   logic [PORT_W-1:0] wdata;
   logic [6:0]        mode_word;
   logic [2:0]        bit_sel;
   mode_word_t        mode_q, mode_nx;
   logic [PORT_W-1:0] rdata;

   ppi_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .strobe_n(wr_n), .released(commit));

   ppi_cmd_decode #(.W(PORT_W)) u_dec (
      .clk(clk), .rst(rst), .wr_n(wr_n), .cs_n(cs_n), .addr(addr),
      .din(din), .commit(commit), .mode_set(mode_set), .bit_op(bit_op),
      .ld_a(ld_a), .ld_b(ld_b), .ld_c(ld_c), .data(wdata),
      .mode_word(mode_word), .bit_sel(bit_sel), .bit_val(bit_val));

   ppi_mode_reg u_mode (
      .clk(clk), .rst(rst), .mode_set(mode_set), .word_in(mode_word),
      .mode_q(mode_q));

   assign mode_nx = mode_word_t'(mode_word);

   ppi_port_latch #(.W(PORT_W)) u_la (
      .clk(clk), .rst(rst), .clr(mode_set),
      .clr_mask({PORT_W{~mode_nx.a_in}}), .ld(ld_a), .ld_data(wdata),
      .bit_we(1'b0), .bit_sel(bit_sel), .bit_val(bit_val), .q(pa_out));

   ppi_port_latch #(.W(PORT_W)) u_lb (
      .clk(clk), .rst(rst), .clr(mode_set),
      .clr_mask({PORT_W{~mode_nx.b_in}}), .ld(ld_b), .ld_data(wdata),
      .bit_we(1'b0), .bit_sel(bit_sel), .bit_val(bit_val), .q(pb_out));

   ppi_port_latch #(.W(PORT_W)) u_lc (
      .clk(clk), .rst(rst), .clr(mode_set),
      .clr_mask({{HALF{~mode_nx.cu_in}}, {HALF{~mode_nx.cl_in}}}),
      .ld(ld_c), .ld_data(wdata),
      .bit_we(bit_op), .bit_sel(bit_sel), .bit_val(bit_val), .q(pc_out));

   ppi_read_mux #(.W(PORT_W)) u_rmux (
      .addr(addr), .mode_q(mode_q), .la(pa_out), .lb(pb_out), .lc(pc_out),
      .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .rdata(rdata));

   assign pa_oe   = {PORT_W{~mode_q.a_in}};
   assign pb_oe   = {PORT_W{~mode_q.b_in}};
   assign pc_oe   = {{HALF{~mode_q.cu_in}}, {HALF{~mode_q.cl_in}}};
   assign dout_oe = ~cs_n & ~rd_n;
   assign dout    = dout_oe ? rdata : '0;

   // R8
   cmd_read_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (dout_oe && addr == SEL_CMD) |-> dout[7]);

   // R9
   pa_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (dout_oe && addr == SEL_PA && pa_oe == '0) |-> (dout == pa_in));

   // R4
   oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
      mode_set |=> (pa_oe[0] == ~$past(din_view_a())));

   function automatic logic din_view_a();
      return mode_nx.a_in;
   endfunction
endmodule

// File: tb/sim_ppi_regif.sv
`timescale 1ns/1ps
module sim_ppi_regif;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       dout_oe;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
   logic [7:0] pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ppi_regif #(.SYNC_STAGES(SYNC), .PORT_W(8)) u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
      .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
      .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
      .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe));

   task automatic check(input string req, input logic [7:0] act,
                        input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_start(input logic [1:0] a, input logic [7:0] d,
                           input bit sel);
      @(negedge clk);
      cs_n = ~sel; addr = a; din = d; wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      wr_start(a, d, 1'b1);
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] v,
                         output logic oe);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      #2;
      v = dout; oe = dout_oe;
      #1;
      rd_n = 1'b1; cs_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, cw, wa, wb, wc, expc;
      logic       oe;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R3 / R8: reset state
      bus_rd(2'b11, v, oe);
      check("R3 reset mode readback", v, 8'h9B);
      check("R3 reset oe", {pa_oe | pb_oe | pc_oe}, 8'h00);
      check("R3 reset latches", {pa_out | pb_out | pc_out}, 8'h00);

      // R2: drive enable
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #2;
      check("R2 no read strobe", {7'd0, dout_oe}, 8'h00);
      cs_n = 1'b1; rd_n = 1'b0; #2;
      check("R2 deselected", {7'd0, dout_oe}, 8'h00);
      cs_n = 1'b0; #2;
      check("R2 selected read", {7'd0, dout_oe}, 8'h01);
      cs_n = 1'b1; rd_n = 1'b1;

      // R1 R4 R5 R6 R8 R9: sweep all sixteen direction settings
      for (int dir = 0; dir < 16; dir++) begin
         logic ai, cui, bi, cli;
         ai = dir[3]; cui = dir[2]; bi = dir[1]; cli = dir[0];
         pa_in = 8'hC3 ^ 8'(dir);
         pb_in = 8'h96 + 8'(dir);
         pc_in = {~4'(dir), 4'(dir)};
         bus_wr(2'b00, 8'hFF);
         bus_wr(2'b01, 8'hFF);
         bus_wr(2'b10, 8'hFF);
         cw = {1'b1, 2'(dir), ai, cui, ai ^ cli, bi, cli};
         bus_wr(2'b11, cw);
         check("R4 pa_oe", pa_oe, {8{~ai}});
         check("R4 pb_oe", pb_oe, {8{~bi}});
         check("R4 R5 pc_oe", pc_oe, {{4{~cui}}, {4{~cli}}});
         if (!ai) check("R6 port A cleared", pa_out, 8'h00);
         if (!bi) check("R6 port B cleared", pb_out, 8'h00);
         if (!cui) check("R6 port C upper cleared", {pc_out[7:4], 4'h0}, 8'h00);
         if (!cli) check("R6 port C lower cleared", {4'h0, pc_out[3:0]}, 8'h00);
         bus_rd(2'b11, v, oe);
         check("R5 R8 mode readback", v, cw);
         wa = {4'(dir), ~4'(dir)};
         wb = 8'(dir * 17) ^ 8'h0F;
         wc = 8'h69 ^ {4'(dir), 4'(dir)};
         bus_wr(2'b00, wa);
         bus_wr(2'b01, wb);
         bus_wr(2'b10, wc);
         bus_rd(2'b00, v, oe);
         check("R1 R9 read port A", v, ai ? pa_in : wa);
         bus_rd(2'b01, v, oe);
         check("R1 R9 read port B", v, bi ? pb_in : wb);
         bus_rd(2'b10, v, oe);
         expc = {cui ? pc_in[7:4] : wc[7:4], cli ? pc_in[3:0] : wc[3:0]};
         check("R1 R9 read port C", v, expc);
         if (!ai) check("R9 port A latch", pa_out, wa);
         if (!bi) check("R9 port B latch", pb_out, wb);
      end

      // R7: bit set then bit clear over all eight port C bits
      bus_wr(2'b11, 8'h80);
      bus_wr(2'b10, 8'h00);
      expc = 8'h00;
      for (int pass = 0; pass < 2; pass++) begin
         for (int b = 0; b < 8; b++) begin
            logic val;
            val = (pass == 0);
            cw = {1'b0, 3'(b) ^ 3'b101, 3'(b), val};
            bus_wr(2'b11, cw);
            expc[b] = val;
            check("R7 bit op port C", pc_out, expc);
         end
      end
      bus_rd(2'b11, v, oe);
      check("R7 mode unchanged by bit ops", v, 8'h80);

      // R7 R9: bit op on an input half leaves the pin view
      bus_wr(2'b11, 8'h81);
      pc_in = 8'h5A;
      bus_wr(2'b11, 8'h03);
      bus_rd(2'b10, v, oe);
      check("R7 input half unaffected", v, 8'h0A);
      check("R7 input half oe", pc_oe, 8'hF0);

      // R10: commit latency
      wr_start(2'b00, 8'h3E, 1'b1);
      repeat (SYNC) @(negedge clk);
      check("R10 not yet committed", pa_out, 8'h00);
      @(negedge clk);
      check("R10 committed", pa_out, 8'h3E);

      // R11: write with chip select high
      wr_start(2'b00, 8'hC1, 1'b0);
      repeat (SYNC + 2) @(negedge clk);
      check("R11 deselected write port A", pa_out, 8'h3E);
      wr_start(2'b11, 8'h9B, 1'b0);
      repeat (SYNC + 2) @(negedge clk);
      bus_rd(2'b11, v, oe);
      check("R11 deselected write mode", v, 8'h81);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule